// File: doc/BRIEF.md
# Decimated-Sample Serial Lane Formatter

This block sits after a digital down-converter and turns its decimated 18-bit output samples into serial bit streams on up to two lanes per channel. It serves two channels, A and B. Each sample word is either complex, with an I and a Q part per channel, or real, where only the I field of each channel is used. The block also makes a frame strobe that marks where each sample frame starts, and a bit-clock toggle at half the lane bit rate, so that a receiver can latch data on both clock edges.

The core clock runs at the lane bit rate, and one clock cycle is one bit period on every active lane. A sample enters with `in_valid` at any point in a frame and is stored. At each frame boundary the block latches the requested configuration, packs the stored samples into the lane words for that configuration, and shifts them out MSB first. The number of bits in a frame depends on the data mode and on the lane count, and so does the frame period. Half-wire operation puts both channels onto the lane-0 output of channel A. To keep the lane rates right, the sample source supplies one sample per frame, or two per frame in real 2-wire mode.

Top module: `dsamp_lane_fmt`

## Requirements
- R1: While reset is high and in the first frame after it, every lane output is 0, `dclk_o` is 0 at the first cycle, `frame_o` is high, and the active format is complex 2-wire with an 18-bit frame.
- R2: Complex 2-wire (`cfg_cplx`=1, `cfg_lanes`=0), 18-bit frame: `lane_a_o[0]` carries A.I, `lane_a_o[1]` A.Q, `lane_b_o[0]` B.I and `lane_b_o[1]` B.Q, each MSB first.
- R3: Complex 1-wire (`cfg_lanes`=1), 36-bit frame: `lane_a_o[0]` carries A.I followed by A.Q, `lane_b_o[0]` carries B.I followed by B.Q, and both lane-1 outputs stay 0.
- R4: Complex half-wire (`cfg_lanes`=2 or 3), 72-bit frame: `lane_a_o[0]` carries A.I, B.I, A.Q, B.Q in that order, and all other lanes stay 0.
- R5: Real 2-wire (`cfg_cplx`=0, `cfg_lanes`=0), 18-bit frame holding two successive samples: lane 0 of each channel carries the I field of the first sample, lane 1 that of the last sample captured before the boundary.
- R6: Real 1-wire, 18-bit frame: `lane_a_o[0]` carries A.I and `lane_b_o[0]` carries B.I of one sample. Both lane-1 outputs stay 0.
- R7: Real half-wire, 36-bit frame: `lane_a_o[0]` carries A.I followed by B.I, and all other lanes stay 0.
- R8: `frame_o` is high during the first half of the bit periods of every frame and low during the second half.
- R9: `dclk_o` inverts on every clock cycle after reset.
- R10: A change of `cfg_cplx` or `cfg_lanes` takes effect only at the next frame boundary. The value sampled at the clock edge that ends a frame sets the format of the next frame.
- R11: A frame uses the first sample captured after the previous boundary as its first sample, and the latest sample after that as its second. A sample presented at the edge that ends a frame belongs to the frame after the next one. If no sample arrives, the previously stored sample is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample word present |
| in_a_i | input | 18 | Channel A in-phase (or real) value |
| in_a_q | input | 18 | Channel A quadrature value |
| in_b_i | input | 18 | Channel B in-phase (or real) value |
| in_b_q | input | 18 | Channel B quadrature value |
| cfg_cplx | input | 1 | 1 = complex samples, 0 = real samples |
| cfg_lanes | input | 2 | 0 = 2-wire, 1 = 1-wire, 2 or 3 = half-wire |
| lane_a_o | output | 2 | Channel A lane bits (bit 0 = lane 0) |
| lane_b_o | output | 2 | Channel B lane bits (bit 0 = lane 0) |
| frame_o | output | 1 | Frame strobe |
| dclk_o | output | 1 | DDR bit-clock toggle |

## Verification
The hardest condition to reach from the ports is a format change that arrives in the middle of a frame whose length differs from that of the new format, together with a sample that arrives on the exact edge that closes a frame. The stimulus walks through all six formats and the spare lane code. Each phase lasts three frames plus seven bits, so every switch lands mid-frame. One phase asserts `in_valid` only on the last bit of each frame, and another sends no samples at all, so that the stored samples are repeated. The model predicts every lane bit, the strobe and the clock toggle on every cycle.

// File: rtl/dsamp_lane_fmt_pkg.sv
package dsamp_lane_fmt_pkg;

    parameter int SAMP_W = 18;
    localparam int FW    = 4 * SAMP_W;
    localparam int CNT_W = $clog2(FW + 1);

    typedef enum logic [1:0] {
        LM_TWO  = 2'd0,
        LM_ONE  = 2'd1,
        LM_HALF = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic       cplx;
        lane_mode_e lanes;
    } fmt_t;

    typedef struct packed {
        logic [SAMP_W-1:0] a_i;
        logic [SAMP_W-1:0] a_q;
        logic [SAMP_W-1:0] b_i;
        logic [SAMP_W-1:0] b_q;
    } smp_t;

    function automatic lane_mode_e lane_decode(input logic [1:0] code);
        case (code)
            2'd0:    return LM_TWO;
            2'd1:    return LM_ONE;
            default: return LM_HALF;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(input fmt_t f);
        int n;
        if (f.cplx) begin
            case (f.lanes)
                LM_TWO:  n = SAMP_W;
                LM_ONE:  n = 2 * SAMP_W;
                default: n = 4 * SAMP_W;
            endcase
        end else begin
            case (f.lanes)
                LM_HALF: n = 2 * SAMP_W;
                default: n = SAMP_W;
            endcase
        end
        return CNT_W'(n);
    endfunction

endpackage

// File: rtl/dsamp_frame_timer.sv
module dsamp_frame_timer
    import dsamp_lane_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] len,
    output logic             last,
    output logic             frame_o,
    output logic             dclk_o
);

    logic [CNT_W-1:0] cnt;

    assign last    = (cnt == len - CNT_W'(1));
    assign frame_o = (cnt < (len >> 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dclk_o <= 1'b0;
        end else begin
            cnt    <= last ? '0 : cnt + CNT_W'(1);
            dclk_o <= ~dclk_o;
        end
    end

    AST_DCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (dclk_o != $past(dclk_o)));                       // R9

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < len);                                                        // R8

    AST_STB_START: assert property (@(posedge clk) disable iff (rst)
        last |=> frame_o);                                                 // R8

endmodule

// File: rtl/dsamp_sample_capture.sv
module dsamp_sample_capture
    import dsamp_lane_fmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  smp_t in_smp,
    input  logic load,
    output smp_t slot0,
    output smp_t slot1
);

    logic ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot0 <= '0;
            slot1 <= '0;
            ptr   <= 1'b0;
        end else begin
            if (in_valid) begin
                if (load || !ptr) slot0 <= in_smp;
                else              slot1 <= in_smp;
            end
            ptr <= load ? in_valid : (ptr | in_valid);
        end
    end

    AST_SLOT0_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!load && ptr) |=> $stable(slot0));                                // R11

    AST_SLOT1_KEEP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(slot1));                                     // R11

endmodule

// File: rtl/dsamp_lane_packer.sv
module dsamp_lane_packer
    import dsamp_lane_fmt_pkg::*;
(
    input  fmt_t              fmt,
    input  smp_t              s0,
    input  smp_t              s1,
    output logic [3:0][FW-1:0] words
);

    localparam int PAD1 = FW - SAMP_W;
    localparam int PAD2 = FW - 2 * SAMP_W;

    // word index: 0 = A lane 0, 1 = A lane 1, 2 = B lane 0, 3 = B lane 1
    always_comb begin
        words = '0;
        if (fmt.cplx) begin
            case (fmt.lanes)
                LM_TWO: begin
                    words[0] = {s0.a_i, {PAD1{1'b0}}};
                    words[1] = {s0.a_q, {PAD1{1'b0}}};
                    words[2] = {s0.b_i, {PAD1{1'b0}}};
                    words[3] = {s0.b_q, {PAD1{1'b0}}};
                end
                LM_ONE: begin
                    words[0] = {s0.a_i, s0.a_q, {PAD2{1'b0}}};
                    words[2] = {s0.b_i, s0.b_q, {PAD2{1'b0}}};
                end
                default: words[0] = {s0.a_i, s0.b_i, s0.a_q, s0.b_q};
            endcase
        end else begin
            case (fmt.lanes)
                LM_TWO: begin
                    words[0] = {s0.a_i, {PAD1{1'b0}}};
                    words[1] = {s1.a_i, {PAD1{1'b0}}};
                    words[2] = {s0.b_i, {PAD1{1'b0}}};
                    words[3] = {s1.b_i, {PAD1{1'b0}}};
                end
                LM_ONE: begin
                    words[0] = {s0.a_i, {PAD1{1'b0}}};
                    words[2] = {s0.b_i, {PAD1{1'b0}}};
                end
                default: words[0] = {s0.a_i, s0.b_i, {PAD2{1'b0}}};
            endcase
        end
    end

endmodule

// File: rtl/dsamp_lane_fmt.sv
module dsamp_lane_fmt
    import dsamp_lane_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] in_a_i,
    input  logic [SAMP_W-1:0] in_a_q,
    input  logic [SAMP_W-1:0] in_b_i,
    input  logic [SAMP_W-1:0] in_b_q,
    input  logic              cfg_cplx,
    input  logic [1:0]        cfg_lanes,
    output logic [1:0]        lane_a_o,
    output logic [1:0]        lane_b_o,
    output logic              frame_o,
    output logic              dclk_o
);

    localparam int NLANE = 4;

    fmt_t                   fmt_in, fmt_q;
    smp_t                   in_smp, slot0, slot1;
    logic                   last;
    logic [NLANE-1:0][FW-1:0] packed_w;
    logic [NLANE-1:0][FW-1:0] shreg;

    assign fmt_in.cplx  = cfg_cplx;
    assign fmt_in.lanes = lane_decode(cfg_lanes);
    assign in_smp       = '{a_i: in_a_i, a_q: in_a_q, b_i: in_b_i, b_q: in_b_q};

    always_ff @(posedge clk) begin
        if (rst)       fmt_q <= '{cplx: 1'b1, lanes: LM_TWO};
        else if (last) fmt_q <= fmt_in;
    end

    dsamp_frame_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .len     (frame_len(fmt_q)),
        .last    (last),
        .frame_o (frame_o),
        .dclk_o  (dclk_o)
    );

    dsamp_sample_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_smp   (in_smp),
        .load     (last),
        .slot0    (slot0),
        .slot1    (slot1)
    );

    dsamp_lane_packer u_packer (
        .fmt   (fmt_in),
        .s0    (slot0),
        .s1    (slot1),
        .words (packed_w)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)       shreg[g] <= '0;
            else if (last) shreg[g] <= packed_w[g];
            else           shreg[g] <= {shreg[g][FW-2:0], 1'b0};
        end
    end

    assign lane_a_o = {shreg[1][FW-1], shreg[0][FW-1]};
    assign lane_b_o = {shreg[3][FW-1], shreg[2][FW-1]};

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(fmt_q));                                         // R10

    AST_LANE1_IDLE: assert property (@(posedge clk) disable iff (rst)
        (fmt_q.lanes != LM_TWO) |-> (lane_a_o[1] == 1'b0 && lane_b_o[1] == 1'b0)); // R3

    AST_HALF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (fmt_q.lanes == LM_HALF) |-> (lane_b_o == 2'b00));                 // R4

endmodule

// File: tb/test_dsamp_lane_fmt.sv
`timescale 1ns/1ps
module test_dsamp_lane_fmt;

    localparam int SW = 18;
    localparam int FWB = 4 * SW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] ai = '0, aq = '0, bi = '0, bq = '0;
    logic          cplx = 1'b1;
    logic [1:0]    lsel = 2'd0;
    logic [1:0]    lane_a, lane_b;
    logic          frame, dclk;

    int total = 0;
    int bad   = 0;
    string phase = "";

    // behavioural model state
    bit              m_cplx;
    logic [1:0]      m_lsel;
    int              m_pos, m_len;
    logic [FWB-1:0]  m_w [4];
    logic [FWB-1:0]  m_s0, m_s1;
    bit              m_wc;
    bit              m_dclk;

    always #4 clk = ~clk;

    dsamp_lane_fmt i_dsamp_lane_fmt (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a_i(ai), .in_a_q(aq), .in_b_i(bi), .in_b_q(bq),
        .cfg_cplx(cplx), .cfg_lanes(lsel),
        .lane_a_o(lane_a), .lane_b_o(lane_b),
        .frame_o(frame), .dclk_o(dclk)
    );

    function automatic int flen(bit c, logic [1:0] ls);
        if (c) return (ls == 2'd0) ? SW : (ls == 2'd1) ? 2*SW : 4*SW;
        return (ls[1]) ? 2*SW : SW;
    endfunction

    function automatic string lane_req(bit c, logic [1:0] ls);
        if (c) return (ls == 2'd0) ? "R2" : (ls == 2'd1) ? "R3" : "R4";
        return (ls == 2'd0) ? "R5" : (ls == 2'd1) ? "R6" : "R7";
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s %s pos=%0d actual=%0d expected=%0d",
                     req, phase, what, m_pos, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cplx = 1'b1; m_lsel = 2'd0; m_pos = 0; m_len = SW;
        for (int k = 0; k < 4; k++) m_w[k] = '0;
        m_s0 = '0; m_s1 = '0; m_wc = 1'b0; m_dclk = 1'b0;
    endtask

    // sample layout in model words: [71:54]=A.I [53:36]=A.Q [35:18]=B.I [17:0]=B.Q
    task automatic build_frame();
        logic [SW-1:0] xai, xaq, xbi, xbq, yai, ybi;
        logic [SW-1:0] z;
        z = '0;
        {xai, xaq, xbi, xbq} = m_s0;
        yai = m_s1[71:54]; ybi = m_s1[35:18];
        for (int k = 0; k < 4; k++) m_w[k] = '0;
        if (cplx) begin
            if (lsel == 2'd0) begin
                m_w[0] = {xai, z, z, z}; m_w[1] = {xaq, z, z, z};
                m_w[2] = {xbi, z, z, z}; m_w[3] = {xbq, z, z, z};
            end else if (lsel == 2'd1) begin
                m_w[0] = {xai, xaq, z, z}; m_w[2] = {xbi, xbq, z, z};
            end else begin
                m_w[0] = {xai, xbi, xaq, xbq};
            end
        end else begin
            if (lsel == 2'd0) begin
                m_w[0] = {xai, z, z, z}; m_w[1] = {yai, z, z, z};
                m_w[2] = {xbi, z, z, z}; m_w[3] = {ybi, z, z, z};
            end else if (lsel == 2'd1) begin
                m_w[0] = {xai, z, z, z}; m_w[2] = {xbi, z, z, z};
            end else begin
                m_w[0] = {xai, xbi, z, z};
            end
        end
    endtask

    // applies the effect of the coming clock edge with the inputs now driven
    task automatic model_step();
        bit lst;
        lst = (m_pos == m_len - 1);
        if (lst) begin
            build_frame();
            m_cplx = cplx; m_lsel = lsel; m_len = flen(cplx, lsel); m_pos = 0;
        end else begin
            m_pos++;
        end
        if (in_valid) begin
            if (lst || !m_wc) m_s0 = {ai, aq, bi, bq};
            else              m_s1 = {ai, aq, bi, bq};
        end
        m_wc = lst ? in_valid : (m_wc | in_valid);
        m_dclk = ~m_dclk;
    endtask

    task automatic check_outputs();
        string r;
        r = lane_req(m_cplx, m_lsel);
        chk(r, "lane_a0", int'(lane_a[0]), int'(m_w[0][FWB-1-m_pos]));
        chk(r, "lane_a1", int'(lane_a[1]), int'(m_w[1][FWB-1-m_pos]));
        chk(r, "lane_b0", int'(lane_b[0]), int'(m_w[2][FWB-1-m_pos]));
        chk(r, "lane_b1", int'(lane_b[1]), int'(m_w[3][FWB-1-m_pos]));
        chk("R8", "frame", int'(frame), (m_pos < m_len / 2) ? 1 : 0);
        chk("R9", "dclk", int'(dclk), int'(m_dclk));
    endtask

    // vp: 0 none, 1 one sample at pos 3, 2 samples at pos 3 and 9, 3 sample on last bit
    task automatic tick(bit c, logic [1:0] ls, int vp);
        bit v;
        @(negedge clk);
        check_outputs();
        v = (vp == 1 && m_pos == 3) || (vp == 2 && (m_pos == 3 || m_pos == 9)) ||
            (vp == 3 && m_pos == m_len - 1);
        cplx = c; lsel = ls; in_valid = v;
        ai = SW'($urandom); aq = SW'($urandom); bi = SW'($urandom); bq = SW'($urandom);
        model_step();
    endtask

    task automatic run_phase(string tag, bit c, logic [1:0] ls, int vp);
        int n;
        phase = tag;
        n = 3 * flen(c, ls) + 7;
        for (int k = 0; k < n; k++) tick(c, ls, vp);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is held
        chk("R1", "lane_a", int'(lane_a), 0);
        chk("R1", "lane_b", int'(lane_b), 0);
        chk("R1", "frame", int'(frame), 1);
        chk("R1", "dclk", int'(dclk), 0);
        rst = 1'b0;
        cplx = 1'b1; lsel = 2'd0; in_valid = 1'b0;
        model_step();
        phase = "R1_first_frame";
        for (int k = 0; k < SW - 1; k++) tick(1'b1, 2'd0, 0);
        run_phase("R2_c2",        1'b1, 2'd0, 1);
        run_phase("R3_c1_R10",    1'b1, 2'd1, 1);
        run_phase("R4_ch_R10",    1'b1, 2'd2, 1);
        run_phase("R5_r2_R10",    1'b0, 2'd0, 2);
        run_phase("R6_r1_R10",    1'b0, 2'd1, 1);
        run_phase("R7_rh_R10",    1'b0, 2'd2, 1);
        run_phase("R4_code3",     1'b1, 2'd3, 1);
        run_phase("R11_edge",     1'b0, 2'd0, 3);
        run_phase("R11_nosample", 1'b1, 2'd1, 0);
        run_phase("R5_again",     1'b0, 2'd0, 2);
        run_phase("R7_code3",     1'b0, 2'd3, 1);
        run_phase("R2_back",      1'b1, 2'd0, 1);
        @(negedge clk);
        check_outputs();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule